// File: doc/BRIEF.md
# Event Frame Assembler

The assembler turns one trigger into one event record: a stream of 32-bit words sent toward a memory board. Every record opens with four header words that carry the event number, a depth value, the number of hit words and the absolute time. These are followed by two words per ADC clock index, then by the encoded hit words, and finally by an all-ones closing word. The block keeps two counters of its own, an event counter and a free-running 28-bit time counter clocked at 100 MHz. Each counter has a separate clear input.

The ADC stream delivers one set of four 10-bit channels per clock index, and the block numbers the indices itself, from 0 up to SAMPLES-1. The hit stream delivers chip, strip and clock fields for each hit word. Both input streams use valid/ready handshakes, because each ADC set becomes two output words. The output side has a valid strobe and no backpressure. Depth and hit count are presented together with the trigger. All three values are captured at the trigger, so they stay fixed for the whole record.

Top module: `event_frame_asm`

## Requirements
- R1: A record starts with four header words, each with bits [31:30] = 00. Bits [29:28] take the values 00, 01, 10, 11 in that order, and bits [27:0] hold the value.
- R2: The sub-flag 00 value is the number of records completed since reset or since the last count clear.
- R3: The sub-flag 01 value is depthIn and the sub-flag 10 value is hitCountIn, both as sampled with the trigger.
- R4: The time counter reads 0 after clockReset is sampled and increases by one at every later edge. The sub-flag 11 value is the counter value in the cycle the trigger is sampled.
- R5: After the header come 2*SAMPLES ADC words. For each index k counting up from 0, the word {10, ch0, ch1, k} comes first and {11, ch2, ch3, k} comes right after it. Channels sit in bits [29:20] and [19:10], and k sits in bits [9:0].
- R6: adcReady is high only while the block waits for the first word of an index. Cycles without a handshake produce no ADC word, and adcReady is low once all indices of the record are taken.
- R7: Exactly hitCountIn hit words follow the ADC words, in arrival order, each formed as {01, 0, hitChip[2:0], hitStrips[15:0], hitClock[9:0]}. A hit count of zero goes straight to the closing word.
- R8: Each record ends with the word 0xFFFFFFFF and holds exactly 4 + 2*SAMPLES + hitCountIn + 1 words. No word follows until the next trigger.
- R9: A trigger that arrives while a record is in progress is ignored.
- R10: countReset clears the event counter, so the next record carries event number 0.
- R11: While reset is held, outValid, adcReady and hitReady are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 100 MHz clock |
| rstN | input | 1 | Active-low synchronous reset |
| trigger | input | 1 | Starts a record when idle |
| countReset | input | 1 | Clears the event counter |
| clockReset | input | 1 | Clears the time counter |
| depthIn | input | 28 | Depth value captured at trigger |
| hitCountIn | input | CNT_W | Number of hit words for this record, captured at trigger |
| adcValid | input | 1 | ADC channel set valid |
| adcReady | output | 1 | ADC channel set accepted this cycle if valid |
| adcCh0 | input | 10 | ADC channel 0 |
| adcCh1 | input | 10 | ADC channel 1 |
| adcCh2 | input | 10 | ADC channel 2 |
| adcCh3 | input | 10 | ADC channel 3 |
| hitValid | input | 1 | Hit word valid |
| hitReady | output | 1 | Hit word accepted this cycle if valid |
| hitChip | input | 3 | Chip number of the hit word |
| hitStrips | input | 16 | Strip pattern of the hit word |
| hitClock | input | 10 | Clock field of the hit word |
| outValid | output | 1 | Output word valid |
| outData | output | 32 | Output word |

## Verification
The hardest case to reach is a trigger pulse that lands in the middle of a record that is already running. It must change neither the length nor the content of that record, and it must not start a second record afterwards. The stimulus raises a second trigger about a hundred cycles into a record, while ADC words are still streaming with gaps. It then checks that the count of collected words matches the expected record length exactly, and that the count stays the same over a quiet window after the closing word. The time-header check takes a similar approach: it clears the time counter a known number of cycles before the trigger, so that the expected time value is an exact number.

// File: rtl/efa_pkg.sv
package efa_pkg;

  localparam int WORD_W     = 32;
  localparam int VAL_W      = 28;
  localparam int ADC_W      = 10;
  localparam int IDX_FLD_W  = 10;

  localparam logic [1:0] FLAG_HDR  = 2'b00;
  localparam logic [1:0] FLAG_HIT  = 2'b01;
  localparam logic [1:0] FLAG_ADCA = 2'b10;
  localparam logic [1:0] FLAG_ADCB = 2'b11;

  localparam logic [WORD_W-1:0] CLOSE_WORD = '1;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_HDR  = 3'd1,
    ST_ADC  = 3'd2,
    ST_HIT  = 3'd3,
    ST_FOOT = 3'd4
  } frame_state_e;

  typedef struct packed {
    logic       latch;
    logic       emitHdr;
    logic [1:0] hdrSel;
    logic       emitAdcA;
    logic       emitAdcB;
    logic       captureAdc;
    logic       emitHit;
    logic       emitFoot;
    logic       incEvent;
  } frame_strobe_t;

endpackage

// File: rtl/efa_ctrl.sv
module efa_ctrl
  import efa_pkg::*;
#(
  parameter int SAMPLES = 1024,
  parameter int CNT_W   = 12,
  parameter int IDX_W   = 10
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               trigger,
  input  logic [CNT_W-1:0]   hitCountIn,
  input  logic               adcValid,
  input  logic               hitValid,
  output logic               adcReady,
  output logic               hitReady,
  output logic [IDX_W-1:0]   sampleIdx,
  output frame_strobe_t      str
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SAMPLES - 1);

  frame_state_e     state, stateNext;
  logic [1:0]       hdrIdx, hdrNext;
  logic             phase, phaseNext;
  logic [IDX_W-1:0] idxNext;
  logic [CNT_W-1:0] hitRemain, remainNext;

  always_comb begin
    str        = '0;
    adcReady   = 1'b0;
    hitReady   = 1'b0;
    stateNext  = state;
    hdrNext    = hdrIdx;
    phaseNext  = phase;
    idxNext    = sampleIdx;
    remainNext = hitRemain;
    unique case (state)
      ST_IDLE: begin
        if (trigger) begin
          str.latch  = 1'b1;
          stateNext  = ST_HDR;
          hdrNext    = 2'd0;
          remainNext = hitCountIn;
        end
      end
      ST_HDR: begin
        str.emitHdr = 1'b1;
        str.hdrSel  = hdrIdx;
        hdrNext     = hdrIdx + 2'd1;
        if (hdrIdx == 2'd3) begin
          stateNext = ST_ADC;
          phaseNext = 1'b0;
          idxNext   = '0;
        end
      end
      ST_ADC: begin
        if (!phase) begin
          adcReady = 1'b1;
          if (adcValid) begin
            str.emitAdcA   = 1'b1;
            str.captureAdc = 1'b1;
            phaseNext      = 1'b1;
          end
        end else begin
          str.emitAdcB = 1'b1;
          phaseNext    = 1'b0;
          if (sampleIdx == LAST_IDX) begin
            idxNext   = '0;
            stateNext = (hitRemain == '0) ? ST_FOOT : ST_HIT;
          end else begin
            idxNext = sampleIdx + IDX_W'(1);
          end
        end
      end
      ST_HIT: begin
        hitReady = 1'b1;
        if (hitValid) begin
          str.emitHit = 1'b1;
          remainNext  = hitRemain - CNT_W'(1);
          if (hitRemain == CNT_W'(1)) stateNext = ST_FOOT;
        end
      end
      ST_FOOT: begin
        str.emitFoot = 1'b1;
        str.incEvent = 1'b1;
        stateNext    = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      hdrIdx    <= 2'd0;
      phase     <= 1'b0;
      sampleIdx <= '0;
      hitRemain <= '0;
    end else begin
      state     <= stateNext;
      hdrIdx    <= hdrNext;
      phase     <= phaseNext;
      sampleIdx <= idxNext;
      hitRemain <= remainNext;
    end
  end

  // R5: the second word of an index always follows the first in the next cycle
  p_adc_pair_r5: assert property (@(posedge clk) disable iff (!rstN)
    str.emitAdcA |=> str.emitAdcB);

  // R8: at most one word source is selected per cycle
  p_single_emit_r8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({str.emitHdr, str.emitAdcA, str.emitAdcB, str.emitHit, str.emitFoot}));

  // R7: the hit phase is entered only with hit words still owed
  p_hit_budget_r7: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HIT) |-> (hitRemain != '0));

  // R9: a trigger during a record never re-arms the capture
  p_busy_ignore_r9: assert property (@(posedge clk) disable iff (!rstN)
    (str.emitAdcA || str.emitAdcB || str.emitHit) |-> !str.latch);

endmodule

// File: rtl/efa_datapath.sv
module efa_datapath
  import efa_pkg::*;
#(
  parameter int CNT_W = 12,
  parameter int IDX_W = 10
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               countReset,
  input  logic               clockReset,
  input  frame_strobe_t      str,
  input  logic [IDX_W-1:0]   sampleIdx,
  input  logic [VAL_W-1:0]   depthIn,
  input  logic [CNT_W-1:0]   hitCountIn,
  input  logic [ADC_W-1:0]   adcCh0,
  input  logic [ADC_W-1:0]   adcCh1,
  input  logic [ADC_W-1:0]   adcCh2,
  input  logic [ADC_W-1:0]   adcCh3,
  input  logic [2:0]         hitChip,
  input  logic [15:0]        hitStrips,
  input  logic [9:0]         hitClock,
  output logic               outValid,
  output logic [WORD_W-1:0]  outData
);

  logic [VAL_W-1:0] eventNo, absTime;
  logic [VAL_W-1:0] evtHold, timeHold, depthHold, cntHold;
  logic [ADC_W-1:0] holdCh [2];
  logic [VAL_W-1:0] hdrValue;
  logic [IDX_FLD_W-1:0] idxField;
  logic [WORD_W-1:0] nextWord;
  logic              anyEmit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      absTime <= '0;
    end else if (clockReset) begin
      absTime <= '0;
    end else begin
      absTime <= absTime + VAL_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      eventNo <= '0;
    end else if (countReset) begin
      eventNo <= '0;
    end else if (str.incEvent) begin
      eventNo <= eventNo + VAL_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      evtHold   <= '0;
      timeHold  <= '0;
      depthHold <= '0;
      cntHold   <= '0;
    end else if (str.latch) begin
      evtHold   <= eventNo;
      timeHold  <= absTime;
      depthHold <= depthIn;
      cntHold   <= VAL_W'(hitCountIn);
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_hold
    logic [ADC_W-1:0] chIn;
    assign chIn = (g == 0) ? adcCh2 : adcCh3;
    always_ff @(posedge clk) begin
      if (!rstN) holdCh[g] <= '0;
      else if (str.captureAdc) holdCh[g] <= chIn;
    end
  end

  always_comb begin
    unique case (str.hdrSel)
      2'd0:    hdrValue = evtHold;
      2'd1:    hdrValue = depthHold;
      2'd2:    hdrValue = cntHold;
      default: hdrValue = timeHold;
    endcase
  end

  assign idxField = IDX_FLD_W'(sampleIdx);
  assign anyEmit  = str.emitHdr | str.emitAdcA | str.emitAdcB | str.emitHit | str.emitFoot;

  always_comb begin
    if (str.emitHdr)       nextWord = {FLAG_HDR, str.hdrSel, hdrValue};
    else if (str.emitAdcA) nextWord = {FLAG_ADCA, adcCh0, adcCh1, idxField};
    else if (str.emitAdcB) nextWord = {FLAG_ADCB, holdCh[0], holdCh[1], idxField};
    else if (str.emitHit)  nextWord = {FLAG_HIT, 1'b0, hitChip, hitStrips, hitClock};
    else                   nextWord = CLOSE_WORD;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outData  <= '0;
    end else begin
      outValid <= anyEmit;
      outData  <= nextWord;
    end
  end

  // R10: a count clear leaves the event counter at zero
  p_evt_clear_r10: assert property (@(posedge clk) disable iff (!rstN)
    countReset |=> (eventNo == '0));

  // R4: a clock clear leaves the time counter at zero
  p_time_clear_r4: assert property (@(posedge clk) disable iff (!rstN)
    clockReset |=> (absTime == '0));

  // R4: without a clear the time counter advances by one per cycle
  p_time_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    !clockReset |=> (absTime == $past(absTime) + VAL_W'(1)));

  // R8: the closing strobe produces the all-ones word
  p_footer_r8: assert property (@(posedge clk) disable iff (!rstN)
    str.emitFoot |=> (outValid && outData == CLOSE_WORD));

endmodule

// File: rtl/event_frame_asm.sv
module event_frame_asm
  import efa_pkg::*;
#(
  parameter int SAMPLES = 1024,
  parameter int CNT_W   = 12,
  localparam int IDX_W  = (SAMPLES > 1) ? $clog2(SAMPLES) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              trigger,
  input  logic              countReset,
  input  logic              clockReset,
  input  logic [27:0]       depthIn,
  input  logic [CNT_W-1:0]  hitCountIn,
  input  logic              adcValid,
  output logic              adcReady,
  input  logic [9:0]        adcCh0,
  input  logic [9:0]        adcCh1,
  input  logic [9:0]        adcCh2,
  input  logic [9:0]        adcCh3,
  input  logic              hitValid,
  output logic              hitReady,
  input  logic [2:0]        hitChip,
  input  logic [15:0]       hitStrips,
  input  logic [9:0]        hitClock,
  output logic              outValid,
  output logic [31:0]       outData
);

  frame_strobe_t    str;
  logic [IDX_W-1:0] sampleIdx;

  efa_ctrl #(
    .SAMPLES (SAMPLES),
    .CNT_W   (CNT_W),
    .IDX_W   (IDX_W)
  ) i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .trigger    (trigger),
    .hitCountIn (hitCountIn),
    .adcValid   (adcValid),
    .hitValid   (hitValid),
    .adcReady   (adcReady),
    .hitReady   (hitReady),
    .sampleIdx  (sampleIdx),
    .str        (str)
  );

  efa_datapath #(
    .CNT_W (CNT_W),
    .IDX_W (IDX_W)
  ) i_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .countReset (countReset),
    .clockReset (clockReset),
    .str        (str),
    .sampleIdx  (sampleIdx),
    .depthIn    (depthIn),
    .hitCountIn (hitCountIn),
    .adcCh0     (adcCh0),
    .adcCh1     (adcCh1),
    .adcCh2     (adcCh2),
    .adcCh3     (adcCh3),
    .hitChip    (hitChip),
    .hitStrips  (hitStrips),
    .hitClock   (hitClock),
    .outValid   (outValid),
    .outData    (outData)
  );

  // R1: every header word after the first directly follows its predecessor
  p_hdr_order_r1: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outData[31:30] == FLAG_HDR && outData[29:28] != 2'd0) |->
      ($past(outValid) && $past(outData[31:30]) == FLAG_HDR &&
       $past(outData[29:28]) == outData[29:28] - 2'd1));

  // R11: no handshake or output while reset is held
  p_reset_quiet_r11: assert property (@(posedge clk)
    $past(!rstN) |-> (!outValid && !adcReady && !hitReady));

endmodule

// File: tb/test_event_frame_asm.sv
module test_event_frame_asm;

  localparam int SAMPLES = 1024;
  localparam int CNT_W   = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic trigger = 1'b0, countReset = 1'b0, clockReset = 1'b0;
  logic [27:0] depthIn = '0;
  logic [CNT_W-1:0] hitCountIn = '0;
  logic adcValid = 1'b0, adcReady;
  logic [9:0] adcCh0 = '0, adcCh1 = '0, adcCh2 = '0, adcCh3 = '0;
  logic hitValid = 1'b0, hitReady;
  logic [2:0] hitChip = '0;
  logic [15:0] hitStrips = '0;
  logic [9:0] hitClock = '0;
  logic outValid;
  logic [31:0] outData;

  int checks = 0;
  int errors = 0;
  int expEvt = 0;
  logic [31:0] q[$];

  always #5 clk = ~clk;

  event_frame_asm #(.SAMPLES(SAMPLES), .CNT_W(CNT_W)) i_event_frame_asm (
    .clk(clk), .rstN(rstN), .trigger(trigger), .countReset(countReset),
    .clockReset(clockReset), .depthIn(depthIn), .hitCountIn(hitCountIn),
    .adcValid(adcValid), .adcReady(adcReady), .adcCh0(adcCh0), .adcCh1(adcCh1),
    .adcCh2(adcCh2), .adcCh3(adcCh3), .hitValid(hitValid), .hitReady(hitReady),
    .hitChip(hitChip), .hitStrips(hitStrips), .hitClock(hitClock),
    .outValid(outValid), .outData(outData)
  );

  always @(negedge clk) if (rstN && outValid) q.push_back(outData);

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [9:0] chVal(int s, int c, int seed);
    return 10'((s * 7 + c * 131 + seed * 17) % 509);
  endfunction

  function automatic logic [31:0] hitWord(int j, int seed);
    return {2'b01, 1'b0, 3'((j + seed) % 8), 16'((j * 4099 + seed * 5) | 1),
            10'((j * 37 + seed) % 1024)};
  endfunction

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic test_reset();
    repeat (3) @(negedge clk);
    check(outValid == 1'b0, "R11 outValid in reset", 32'(outValid), 0);
    check(adcReady == 1'b0, "R11 adcReady in reset", 32'(adcReady), 0);
    check(hitReady == 1'b0, "R11 hitReady in reset", 32'(hitReady), 0);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic pulse_count_reset();
    @(negedge clk) countReset = 1'b1;
    @(negedge clk) countReset = 1'b0;
    expEvt = 0;
  endtask

  // One full record; drives both streams and checks every word.
  task automatic run_record(input int seed, input int hits, input bit gaps,
                            input bit extraTrig, input bit clkRst, input int delay);
    int base;
    int len;
    int bad;
    int firstBad;
    logic [31:0] w;
    logic [31:0] e;
    depthIn    = 28'(seed * 1000 + 7);
    hitCountIn = CNT_W'(hits);
    if (clkRst) begin
      @(negedge clk) clockReset = 1'b1;
      @(negedge clk) clockReset = 1'b0;
      repeat (delay) @(negedge clk);
    end else begin
      @(negedge clk);
    end
    base = q.size();
    trigger = 1'b1;
    @(negedge clk) trigger = 1'b0;
    fork
      begin : adc_drv
        int s = 0;
        int cyc = 0;
        bit acc;
        while (s < SAMPLES) begin
          adcValid = gaps ? (cyc % 3 != 0) : 1'b1;
          adcCh0 = chVal(s, 0, seed); adcCh1 = chVal(s, 1, seed);
          adcCh2 = chVal(s, 2, seed); adcCh3 = chVal(s, 3, seed);
          #1 acc = adcValid && adcReady;
          @(negedge clk);
          cyc++;
          if (acc) s++;
        end
        adcValid = 1'b1;
      end
      begin : hit_drv
        int j = 0;
        int cyc = 0;
        bit acc;
        logic [31:0] hw;
        while (j < hits) begin
          hw = hitWord(j, seed);
          hitValid = gaps ? (cyc % 2 == 0) : 1'b1;
          hitChip = hw[28:26]; hitStrips = hw[25:10]; hitClock = hw[9:0];
          #1 acc = hitValid && hitReady;
          @(negedge clk);
          cyc++;
          if (acc) j++;
        end
        hitValid = 1'b0;
      end
      begin : extra
        if (extraTrig) begin
          repeat (100) @(negedge clk);
          trigger = 1'b1;
          @(negedge clk) trigger = 1'b0;
        end
      end
    join
    len = 4 + 2 * SAMPLES + hits + 1;
    while (q.size() < base + len) @(negedge clk);
    // R6: all indices taken, valid still high, no more ready
    check(adcReady == 1'b0, "R6 adcReady after ADC section", 32'(adcReady), 0);
    adcValid = 1'b0;

    // R1 R2: header 0
    e = {4'b0000, 28'(expEvt)};
    check(q[base] == e, "R1/R2 event number header", q[base], e);
    e = {4'b0001, depthIn};
    check(q[base + 1] == e, "R3 depth header", q[base + 1], e);
    e = {4'b0010, 28'(hits)};
    check(q[base + 2] == e, "R3 hit count header", q[base + 2], e);
    w = q[base + 3];
    if (clkRst) begin
      e = {4'b0011, 28'(delay)};
      check(w == e, "R4 time header after clock clear", w, e);
    end else begin
      check(w[31:28] == 4'b0011, "R1 time header flags", {28'd0, w[31:28]}, 32'h3);
    end

    // R5 (and R6 for gap runs): ADC words in index order, pairs in flag order
    bad = 0;
    firstBad = -1;
    for (int s = 0; s < SAMPLES; s++) begin
      for (int h = 0; h < 2; h++) begin
        e = (h == 0) ? {2'b10, chVal(s, 0, seed), chVal(s, 1, seed), 10'(s)}
                     : {2'b11, chVal(s, 2, seed), chVal(s, 3, seed), 10'(s)};
        if (q[base + 4 + 2 * s + h] != e) begin
          bad++;
          if (firstBad < 0) firstBad = 2 * s + h;
        end
      end
    end
    check(bad == 0, gaps ? "R5/R6 ADC words with gaps" : "R5 ADC words",
          32'(bad), 0);
    if (firstBad >= 0) $display("  first ADC mismatch at word %0d", firstBad);

    // R7: hit words
    bad = 0;
    for (int j = 0; j < hits; j++)
      if (q[base + 4 + 2 * SAMPLES + j] != hitWord(j, seed)) bad++;
    check(bad == 0, "R7 hit words", 32'(bad), 0);

    // R8: closing word
    w = q[base + len - 1];
    check(w == 32'hFFFF_FFFF, "R8 closing word", w, 32'hFFFF_FFFF);

    repeat (20) @(negedge clk);
    check(q.size() == base + len, extraTrig ? "R9 no record from busy trigger"
                                            : "R8 record length",
          32'(q.size() - base), 32'(len));
    expEvt++;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    test_reset();
    run_record(1, 3, 1'b0, 1'b0, 1'b0, 0);   // R1 R2 R3 R5 R7 R8
    run_record(2, 0, 1'b1, 1'b0, 1'b0, 0);   // R6 gaps, R7 zero hits
    run_record(3, 5, 1'b1, 1'b1, 1'b0, 0);   // R9 trigger while busy
    pulse_count_reset();
    run_record(4, 2, 1'b0, 1'b0, 1'b0, 0);   // R10 event number back to 0
    check(q[q.size() - (4 + 2 * SAMPLES + 2 + 1)] == 32'h0,
          "R10 event number after count clear",
          q[q.size() - (4 + 2 * SAMPLES + 2 + 1)], 32'h0);
    run_record(5, 1, 1'b0, 1'b0, 1'b1, 5);   // R4 time header
    run_record(6, 4, 1'b1, 1'b0, 1'b1, 37);  // R4 again, R2 counts on
    finish_run();
  end

endmodule